// File: doc/BRIEF.md
# Multi-Layer Pixel Fetch Buffer Controller

This block keeps four display layers supplied with pixels from memory and tracks a shared output buffer that sits between the blender and the panel. Each layer has its own input FIFO of 32-bit words. Each FIFO has a programmable upper watermark and a programmable lower watermark, and both watermarks are reported as flags. A scheduler picks, in round-robin order, a layer whose FIFO sits below its upper watermark and still has room for a whole burst. It then runs one memory read burst for that layer. A burst always covers 16 pixels, so its byte length follows the pixel encoding chosen for that layer.

The scheduler is a three-state machine. In `FS_IDLE` it looks for an eligible layer, latches that layer and its burst length, and takes the transition *issue* to `FS_REQ`. In `FS_REQ` it holds the request until the memory grants it (transition *granted*) and enters `FS_DATA`. In `FS_DATA` every data beat is written into the chosen FIFO. The last beat takes the transition *burst done* back to `FS_IDLE`.

On the output side the block only counts entries; it does not store the pixel values. When the count reaches an upper watermark, the blend side is stalled. When a panel read leaves the count under a lower watermark, a sticky underrun bit is set, and it stays set until a write-one-to-clear pulse arrives.

Top module: `pixfetch_ctrl`

## Requirements
- R1: After reset no memory request is pending, every input FIFO and the output count are empty, `blend_stall` is 0 when the upper output watermark is above zero, and `underrun` is 0.
- R2: Each layer's 2-bit encoding sets the burst size: 0 means 8 bpp (16 bytes), 1 means 16 bpp (32 bytes), 2 means 32 bpp (64 bytes), and 3 is treated as 32 bpp (64 bytes). `mem_bytes` reports this size while the request is pending, and the burst carries bytes/4 data beats.
- R3: A burst is issued for a layer only while its level is below its upper watermark and its free space is at least one full burst, so an idle fill ends at the first multiple of the burst that reaches the watermark, or the last multiple that fits the 32-word FIFO.
- R4: Eligible layers are served round-robin. The search starts at the layer after the last granted one (layer 0 after reset), ineligible layers are skipped, and only one burst is outstanding at a time.
- R5: `layer_hi_flag[m]` is 1 exactly when layer m's level is greater than or equal to its upper watermark.
- R6: `layer_lo_flag[m]` is 1 exactly when layer m's level is below its lower watermark.
- R7: Each input FIFO returns words in arrival order on `layer_rdata` (show-ahead), and a pop on an empty FIFO has no effect.
- R8: `blend_stall` is 1 exactly when the output count is greater than or equal to the upper output watermark. A `blend_push` is ignored while stalled or when the count is at the 16-entry capacity.
- R9: A `panel_pop` that leaves the output count below the lower output watermark sets `underrun` from the next cycle. A pop on an empty count leaves the count at zero. The bit holds until `underrun_clr`, and a set in the same cycle as a clear wins.
- R10: While in `FS_REQ` without a grant, `mem_req`, `mem_layer` and `mem_bytes` hold steady, and `mem_rvalid` beats that arrive before the grant are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enc | input | 8 | Pixel encoding per layer, 2 bits each, layer m at [2m+1:2m] |
| cfg_in_hi | input | 24 | Upper input watermark per layer, 6 bits each |
| cfg_in_lo | input | 24 | Lower input watermark per layer, 6 bits each |
| cfg_out_hi | input | 5 | Upper output watermark |
| cfg_out_lo | input | 5 | Lower output watermark |
| underrun_clr | input | 1 | Write-one-to-clear pulse for `underrun` |
| mem_req | output | 1 | Burst read request |
| mem_layer | output | 2 | Layer that the pending burst serves |
| mem_bytes | output | 7 | Byte length of the pending burst |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Data beat valid |
| mem_rdata | input | 32 | Data beat |
| layer_pop | input | 4 | Blender consumes one word from layer m |
| layer_rdata | output | 128 | Head word of each layer FIFO, 32 bits per layer |
| layer_hi_flag | output | 4 | Level at or above the upper watermark |
| layer_lo_flag | output | 4 | Level below the lower watermark |
| blend_push | input | 1 | Blender offers one output pixel |
| blend_stall | output | 1 | Output count at or above the upper watermark |
| panel_pop | input | 1 | Panel consumes one output entry |
| underrun | output | 1 | Sticky low-output indication |

## Verification
A wrong level counter in an input FIFO shows up at once on that layer's high and low flags. It also changes how many words a drain returns and the sequence numbers in the popped data, and it appears within one fill at the burst boundaries. A stuck or misdirected round-robin pointer shows up in the order of granted layers within the first few bursts after reset. A wrong output count shows up at `blend_stall` when the upper watermark is swept, and at the `underrun` bit on the cycle after the pop that crosses the lower watermark.

// File: rtl/pixfetch_pkg.sv
package pixfetch_pkg;

    typedef enum logic [1:0] {
        ENC_8BPP  = 2'd0,
        ENC_16BPP = 2'd1,
        ENC_32BPP = 2'd2,
        ENC_RSVD  = 2'd3
    } pix_enc_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_DATA = 2'd2
    } fetch_state_e;

    // bits per pixel for an encoding; the reserved code behaves as 32 bpp
    function automatic logic [5:0] enc_bits(input pix_enc_e e);
        logic [5:0] b;
        unique case (e)
            ENC_8BPP:  b = 6'd8;
            ENC_16BPP: b = 6'd16;
            default:   b = 6'd32;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pf_layer_fifo.sv
module pf_layer_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic [LVL_W-1:0]  hi_thr,
    input  logic [LVL_W-1:0]  lo_thr,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              hi_flag,
    output logic              lo_flag
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && (int'(level) < DEPTH);
    assign pop_ok  = pop && (level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
            end
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= wdata;
        end
    end

    assign rdata   = store[rd_ptr];
    assign hi_flag = (level >= hi_thr);
    assign lo_flag = (level < lo_thr);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(level) < DEPTH));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) && pop && !push |=> (level == '0));

endmodule

// File: rtl/pf_fetch_sched.sv
module pf_fetch_sched
    import pixfetch_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int DEPTH      = 32,
    parameter int LVL_W      = 6,
    parameter int WRD_W      = 5,
    parameter int ID_W       = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_LAYERS-1:0][LVL_W-1:0]       level,
    input  logic [NUM_LAYERS-1:0][LVL_W-1:0]       hi_thr,
    input  logic [NUM_LAYERS-1:0][WRD_W-1:0]       burst_words,
    input  logic                                   mem_gnt,
    input  logic                                   mem_rvalid,
    output logic                                   mem_req,
    output logic [ID_W-1:0]                        mem_layer,
    output logic [WRD_W-1:0]                       mem_words,
    output logic [NUM_LAYERS-1:0]                  push
);
    fetch_state_e          state_q;
    fetch_state_e          state_d;
    logic [NUM_LAYERS-1:0] elig;
    logic                  any_elig;
    logic [ID_W-1:0]       pick;
    logic [ID_W-1:0]       rr_ptr;
    logic [ID_W-1:0]       cur_layer;
    logic [WRD_W-1:0]      cur_words;
    logic [WRD_W-1:0]      beat_cnt;
    logic                  last_beat;

    always_comb begin
        for (int i = 0; i < NUM_LAYERS; i++) begin
            elig[i] = (level[i] < hi_thr[i]) &&
                      ((DEPTH - int'(level[i])) >= int'(burst_words[i])) &&
                      (burst_words[i] != '0);
        end
    end

    // round-robin search starting at rr_ptr
    always_comb begin
        int idx;
        any_elig = 1'b0;
        pick     = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            idx = (int'(rr_ptr) + i) % NUM_LAYERS;
            if (!any_elig && elig[idx]) begin
                any_elig = 1'b1;
                pick     = ID_W'(idx);
            end
        end
    end

    assign last_beat = (beat_cnt == cur_words - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (any_elig) state_d = FS_REQ;
            FS_REQ:  if (mem_gnt) state_d = FS_DATA;
            FS_DATA: if (mem_rvalid && last_beat) state_d = FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr    <= '0;
            cur_layer <= '0;
            cur_words <= '0;
            beat_cnt  <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (any_elig) begin
                        cur_layer <= pick;
                        cur_words <= burst_words[pick];
                        beat_cnt  <= '0;
                    end
                end
                FS_REQ: begin
                    if (mem_gnt) begin
                        rr_ptr <= (int'(cur_layer) == NUM_LAYERS - 1) ? '0
                                                                      : cur_layer + 1'b1;
                    end
                end
                FS_DATA: begin
                    if (mem_rvalid) beat_cnt <= beat_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state_q == FS_REQ);
        mem_layer = cur_layer;
        mem_words = cur_words;
        push      = '0;
        if (state_q == FS_DATA && mem_rvalid) push[cur_layer] = 1'b1;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_layer) && $stable(mem_words));

    // R4
    single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push != '0) |-> !mem_req);

endmodule

// File: rtl/pf_out_level.sv
module pf_out_level #(
    parameter int OUT_DEPTH = 16,
    parameter int OLW       = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blend_push,
    input  logic           panel_pop,
    input  logic [OLW-1:0] out_hi,
    input  logic [OLW-1:0] out_lo,
    input  logic           underrun_clr,
    output logic           blend_stall,
    output logic           underrun
);
    logic [OLW-1:0] lvl_q;
    logic [OLW-1:0] lvl_d;
    logic           push_ok;
    logic           pop_ok;

    assign blend_stall = (lvl_q >= out_hi);
    assign push_ok     = blend_push && !blend_stall && (int'(lvl_q) < OUT_DEPTH);
    assign pop_ok      = panel_pop && (lvl_q != '0);
    assign lvl_d       = lvl_q + OLW'(push_ok) - OLW'(pop_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            underrun <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
            if (panel_pop && (lvl_d < out_lo)) underrun <= 1'b1;
            else if (underrun_clr)             underrun <= 1'b0;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blend_stall |=> (lvl_q <= $past(lvl_q)));

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl_q) <= OUT_DEPTH);

    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(panel_pop));

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !underrun_clr |=> underrun);

endmodule

// File: rtl/pixfetch_ctrl.sv
module pixfetch_ctrl
    import pixfetch_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int DATA_W     = 32,
    parameter int IN_DEPTH   = 32,
    parameter int OUT_DEPTH  = 16,
    parameter int BURST_PX   = 16,
    localparam int LVL_W     = $clog2(IN_DEPTH + 1),
    localparam int OLW       = $clog2(OUT_DEPTH + 1),
    localparam int ID_W      = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int MAX_WORDS = (BURST_PX * 32) / DATA_W,
    localparam int WRD_W     = $clog2(MAX_WORDS + 1),
    localparam int BYTES_W   = $clog2(BURST_PX * 4 + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2*NUM_LAYERS-1:0]      cfg_enc,
    input  logic [NUM_LAYERS*LVL_W-1:0]  cfg_in_hi,
    input  logic [NUM_LAYERS*LVL_W-1:0]  cfg_in_lo,
    input  logic [OLW-1:0]               cfg_out_hi,
    input  logic [OLW-1:0]               cfg_out_lo,
    input  logic                         underrun_clr,
    output logic                         mem_req,
    output logic [ID_W-1:0]              mem_layer,
    output logic [BYTES_W-1:0]           mem_bytes,
    input  logic                         mem_gnt,
    input  logic                         mem_rvalid,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic [NUM_LAYERS-1:0]        layer_pop,
    output logic [NUM_LAYERS*DATA_W-1:0] layer_rdata,
    output logic [NUM_LAYERS-1:0]        layer_hi_flag,
    output logic [NUM_LAYERS-1:0]        layer_lo_flag,
    input  logic                         blend_push,
    output logic                         blend_stall,
    input  logic                         panel_pop,
    output logic                         underrun
);
    logic [NUM_LAYERS-1:0][LVL_W-1:0] level;
    logic [NUM_LAYERS-1:0][LVL_W-1:0] hi_arr;
    logic [NUM_LAYERS-1:0][LVL_W-1:0] lo_arr;
    logic [NUM_LAYERS-1:0][WRD_W-1:0] burst_words;
    logic [NUM_LAYERS-1:0]            push;
    logic [WRD_W-1:0]                 mem_words;

    assign hi_arr = cfg_in_hi;
    assign lo_arr = cfg_in_lo;

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        pix_enc_e enc_g;
        assign enc_g = pix_enc_e'(cfg_enc[2*g +: 2]);
        assign burst_words[g] = WRD_W'((BURST_PX * int'(enc_bits(enc_g))) / DATA_W);

        pf_layer_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (IN_DEPTH),
            .LVL_W  (LVL_W)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push[g]),
            .wdata   (mem_rdata),
            .pop     (layer_pop[g]),
            .hi_thr  (hi_arr[g]),
            .lo_thr  (lo_arr[g]),
            .rdata   (layer_rdata[g*DATA_W +: DATA_W]),
            .level   (level[g]),
            .hi_flag (layer_hi_flag[g]),
            .lo_flag (layer_lo_flag[g])
        );
    end

    pf_fetch_sched #(
        .NUM_LAYERS (NUM_LAYERS),
        .DEPTH      (IN_DEPTH),
        .LVL_W      (LVL_W),
        .WRD_W      (WRD_W),
        .ID_W       (ID_W)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .hi_thr      (hi_arr),
        .burst_words (burst_words),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_req     (mem_req),
        .mem_layer   (mem_layer),
        .mem_words   (mem_words),
        .push        (push)
    );

    assign mem_bytes = BYTES_W'(int'(mem_words) * (DATA_W / 8));

    pf_out_level #(
        .OUT_DEPTH (OUT_DEPTH),
        .OLW       (OLW)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .blend_push   (blend_push),
        .panel_pop    (panel_pop),
        .out_hi       (cfg_out_hi),
        .out_lo       (cfg_out_lo),
        .underrun_clr (underrun_clr),
        .blend_stall  (blend_stall),
        .underrun     (underrun)
    );

    // R3
    push_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));

endmodule

// File: tb/pixfetch_ctrl_bench.sv
`timescale 1ns/1ps
module pixfetch_ctrl_bench;
    localparam int NL = 4;
    localparam int DEPTH = 32;
    localparam int ODEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  cfg_enc = '0;
    logic [23:0] cfg_in_hi = '0;
    logic [23:0] cfg_in_lo = '0;
    logic [4:0]  cfg_out_hi = 5'd16;
    logic [4:0]  cfg_out_lo = 5'd0;
    logic underrun_clr = 1'b0;
    logic mem_req;
    logic [1:0] mem_layer;
    logic [6:0] mem_bytes;
    logic mem_gnt = 1'b0;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0] layer_pop = '0;
    logic [127:0] layer_rdata;
    logic [3:0] layer_hi_flag;
    logic [3:0] layer_lo_flag;
    logic blend_push = 1'b0;
    logic blend_stall;
    logic panel_pop = 1'b0;
    logic underrun;

    int n_chk = 0;
    int n_fail = 0;
    bit mem_en = 1'b1;
    bit resp_busy = 1'b0;
    int ng = 0;
    int glog_layer [64];
    int glog_bytes [64];
    int seq_tx [NL];
    int seq_rx [NL];

    always #2.5 clk = ~clk;

    pixfetch_ctrl u_pixfetch_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enc(cfg_enc), .cfg_in_hi(cfg_in_hi),
        .cfg_in_lo(cfg_in_lo), .cfg_out_hi(cfg_out_hi), .cfg_out_lo(cfg_out_lo),
        .underrun_clr(underrun_clr), .mem_req(mem_req), .mem_layer(mem_layer),
        .mem_bytes(mem_bytes), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .layer_pop(layer_pop), .layer_rdata(layer_rdata),
        .layer_hi_flag(layer_hi_flag), .layer_lo_flag(layer_lo_flag),
        .blend_push(blend_push), .blend_stall(blend_stall), .panel_pop(panel_pop),
        .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // memory model: grant one cycle after a request, then bytes/4 beats
    initial begin
        for (int l = 0; l < NL; l++) seq_tx[l] = 0;
        forever begin
            @(negedge clk);
            if (mem_en && mem_req) begin
                int lay;
                int nb;
                resp_busy = 1'b1;
                lay = int'(mem_layer);
                nb = int'(mem_bytes) / 4;
                if (ng < 64) begin
                    glog_layer[ng] = lay;
                    glog_bytes[ng] = int'(mem_bytes);
                end
                ng++;
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                for (int b = 0; b < nb; b++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = {8'(lay), 24'(seq_tx[lay])};
                    seq_tx[lay]++;
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
                resp_busy = 1'b0;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        int idle = 0;
        int guard = 0;
        while (idle < 6 && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (!mem_req && !resp_busy) idle++;
            else idle = 0;
        end
    endtask

    task automatic set_hi(input int l, input int v);
        cfg_in_hi[l*6 +: 6] = 6'(v);
    endtask

    task automatic set_lo(input int l, input int v);
        cfg_in_lo[l*6 +: 6] = 6'(v);
    endtask

    // pops a layer until empty, checking arrival order (R7)
    task automatic drain(input int l, output int cnt);
        cnt = 0;
        set_lo(l, 1);
        #1;
        while (!layer_lo_flag[l] && cnt < 100) begin
            int got;
            got = int'(layer_rdata[l*32 +: 24]);
            chk(got == seq_rx[l] && layer_rdata[l*32+24 +: 8] == 8'(l),
                "R7 order", got, seq_rx[l]);
            seq_rx[l]++;
            layer_pop[l] = 1'b1;
            @(negedge clk);
            layer_pop[l] = 1'b0;
            cnt++;
            #1;
        end
        @(negedge clk);
    endtask

    function automatic int fill_of(input int hi, input int bw);
        int lvl = 0;
        while (lvl < hi && (DEPTH - lvl) >= bw) lvl += bw;
        return lvl;
    endfunction

    task automatic out_level(output int lvl);
        logic [4:0] save;
        save = cfg_out_hi;
        lvl = 0;
        for (int k = 1; k <= ODEPTH; k++) begin
            cfg_out_hi = 5'(k);
            #0.1;
            if (blend_stall) lvl++;
        end
        cfg_out_hi = save;
        #0.1;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int cnt;
        int lvl;
        int exp_l;
        int bw;
        int his [6];
        int ur_exp;
        his = '{1, 4, 5, 10, 17, 32};
        for (int l = 0; l < NL; l++) seq_rx[l] = 0;

        // R1 reset state
        cfg_in_lo = {4{6'd2}};
        cfg_out_lo = 5'd3;
        do_reset();
        #1;
        chk(mem_req == 1'b0, "R1 no request", int'(mem_req), 0);
        chk(layer_lo_flag == 4'hF, "R1 fifos empty", int'(layer_lo_flag), 15);
        chk(layer_hi_flag == 4'hF, "R1 hi flag at zero watermark", int'(layer_hi_flag), 15);
        chk(blend_stall == 1'b0, "R1 stall clear", int'(blend_stall), 0);
        chk(underrun == 1'b0, "R1 underrun clear", int'(underrun), 0);
        out_level(lvl);
        chk(lvl == 0, "R1 output empty", lvl, 0);
        @(negedge clk);

        // R2 R3 R5 R6 fill sweep on layer 0
        for (int e = 0; e < 4; e++) begin
            for (int h = 0; h < 6; h++) begin
                bw = (e == 0) ? 4 : (e == 1) ? 8 : 16;
                cfg_enc[1:0] = 2'(e);
                ng = 0;
                set_hi(0, his[h]);
                settle();
                exp_l = fill_of(his[h], bw);
                chk(glog_bytes[0] == bw * 4, "R2 burst bytes", glog_bytes[0], bw * 4);
                chk(ng == exp_l / bw, "R3 burst count", ng, exp_l / bw);
                // R5 hi flag at the boundary, restored before the next edge
                set_hi(0, exp_l);
                #1;
                chk(layer_hi_flag[0] == 1'b1, "R5 hi flag at level", int'(layer_hi_flag[0]), 1);
                set_hi(0, 0);
                @(negedge clk);
                if (exp_l < 63) begin
                    set_hi(0, exp_l + 1);
                    #1;
                    chk(layer_hi_flag[0] == 1'b0, "R5 hi flag above level",
                        int'(layer_hi_flag[0]), 0);
                    set_hi(0, 0);
                    @(negedge clk);
                end
                // R6 lo flag sweep
                for (int lo = 0; lo <= DEPTH; lo++) begin
                    set_lo(0, lo);
                    #1;
                    chk(layer_lo_flag[0] == (exp_l < lo), "R6 lo flag",
                        int'(layer_lo_flag[0]), int'(exp_l < lo));
                end
                @(negedge clk);
                drain(0, cnt);
                chk(cnt == exp_l, "R3 fill level", cnt, exp_l);
            end
        end

        // R7 pop on empty is ignored
        layer_pop[0] = 1'b1;
        @(negedge clk);
        layer_pop[0] = 1'b0;
        #1;
        chk(layer_lo_flag[0] == 1'b1, "R7 empty pop ignored", int'(layer_lo_flag[0]), 1);
        @(negedge clk);

        // R4 round-robin, all layers eligible
        do_reset();
        cfg_enc = '0;
        ng = 0;
        cfg_in_hi = {4{6'd8}};
        settle();
        chk(ng == 8, "R4 grant total", ng, 8);
        for (int i = 0; i < 8; i++)
            chk(glog_layer[i] == i % 4, "R4 rr order", glog_layer[i], i % 4);
        cfg_in_hi = '0;
        for (int l = 0; l < NL; l++) begin
            drain(l, cnt);
            chk(cnt == 8, "R4 layer fill", cnt, 8);
        end

        // R4 round-robin skipping layer 2
        do_reset();
        ng = 0;
        cfg_in_hi = {6'd8, 6'd0, 6'd8, 6'd8};
        settle();
        chk(ng == 6, "R4 grant total skip", ng, 6);
        for (int i = 0; i < 6; i++) begin
            int ex;
            ex = (i % 3 == 2) ? 3 : i % 3;
            chk(glog_layer[i] == ex, "R4 rr skip order", glog_layer[i], ex);
        end
        cfg_in_hi = '0;
        for (int l = 0; l < NL; l++) begin
            drain(l, cnt);
            chk(cnt == ((l == 2) ? 0 : 8), "R4 skip fill", cnt, (l == 2) ? 0 : 8);
        end

        // R10 request held until grant; early beats discarded
        do_reset();
        mem_en = 1'b0;
        cfg_enc[3:2] = 2'd1;
        set_hi(1, 8);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk(mem_req && mem_layer == 2'd1 && mem_bytes == 7'd32, "R10 request held",
                int'(mem_bytes), 32);
            if (i < 2) begin
                mem_rvalid = 1'b1;
                mem_rdata = 32'hFFFF_FFFF;
            end else begin
                mem_rvalid = 1'b0;
            end
            @(negedge clk);
        end
        mem_en = 1'b1;
        settle();
        set_hi(1, 0);
        drain(1, cnt);
        chk(cnt == 8, "R10 only granted beats stored", cnt, 8);

        // R8 output count with capacity cap
        for (int n = 0; n <= ODEPTH + 2; n++) begin
            do_reset();
            cfg_out_hi = 5'd16;
            for (int i = 0; i < n; i++) pulse(blend_push);
            out_level(lvl);
            chk(lvl == ((n < ODEPTH) ? n : ODEPTH), "R8 push count", lvl,
                (n < ODEPTH) ? n : ODEPTH);
        end
        do_reset();
        cfg_out_hi = 5'd16;
        cfg_out_lo = 5'd3;
        repeat (6) pulse(blend_push);
        cfg_out_hi = 5'd6;
        #1;
        chk(blend_stall == 1'b1, "R8 stall at watermark", int'(blend_stall), 1);
        cfg_out_hi = 5'd7;
        #1;
        chk(blend_stall == 1'b0, "R8 no stall below", int'(blend_stall), 0);
        cfg_out_hi = 5'd4;
        @(negedge clk);
        repeat (3) pulse(blend_push);
        cfg_out_hi = 5'd16;
        out_level(lvl);
        chk(lvl == 6, "R8 push ignored while stalled", lvl, 6);

        // R9 underrun sticky
        chk(underrun == 1'b0, "R9 no underrun yet", int'(underrun), 0);
        ur_exp = 0;
        for (int i = 0; i < 7; i++) begin
            int after;
            after = (6 - (i + 1) > 0) ? 6 - (i + 1) : 0;
            pulse(panel_pop);
            if (after < 3) ur_exp = 1;
            chk(int'(underrun) == ur_exp, "R9 underrun after pop", int'(underrun), ur_exp);
        end
        out_level(lvl);
        chk(lvl == 0, "R9 pop on empty keeps zero", lvl, 0);
        pulse(underrun_clr);
        chk(underrun == 1'b0, "R9 clear", int'(underrun), 0);
        underrun_clr = 1'b1;
        panel_pop = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        panel_pop = 1'b0;
        chk(underrun == 1'b1, "R9 set wins over clear", int'(underrun), 1);
        pulse(underrun_clr);
        cfg_out_lo = 5'd0;
        pulse(panel_pop);
        chk(underrun == 1'b0, "R9 zero watermark never sets", int'(underrun), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule